// File: doc/BRIEF.md
# Delay-Line Loopback Self-Test Checker

This block watches a RAM-based variable-length delay line and reports when it corrupts data. A four-bit word counter steps once for each half-rate slot in which the delay line's address comparator reports equality. It starts at six and wraps back to six after fifteen, so it produces a sampling point on every tenth step. If that sampling step falls in a write cycle, the two data bits entering the delay line are captured.

The captured bits are stored in complement form. When the delayed copy of the sampled word comes out of the line, the surrounding logic raises a compare-valid strobe. Each bit is then compared against its stored complement with an exclusive-OR. A healthy line makes every exclusive-OR return one. Any bit whose exclusive-OR returns zero sets a sticky error flag. That flag feeds the chip's diagnostic alarm and stays set until software-facing logic pulses a synchronous clear.

Top module: `dlc_selftest`

## Requirements
- R1: The word counter advances only in a cycle where both `half_en` and `addr_eq` are high. In any other cycle it holds its value, and no capture can happen.
- R2: After reset, the counter holds six and `err_flag` is low. No word counts as captured until the first capture.
- R3: Starting from six, the tenth advance (the one taken while the counter holds fifteen) is the sampling step. That step reloads the counter to six.
- R4: A sampling step captures data only if `wr_cycle` is high in the same cycle. Without it, no capture happens and the previously captured word stays in place, but the counter still reloads.
- R5: On a capture, the block stores the value on `wr_bits` (bit i to bit i). It holds that value until the next capture.
- R6: In a cycle with `cmp_valid` high, after at least one capture, the compare fails if any bit of `rd_bits` differs from the corresponding captured `wr_bits` bit.
- R7: A failing compare sets the error flag only while `cmp_valid` is high. Before the first capture since reset, compares never set the flag.
- R8: Once set, `err_flag` stays high until it is cleared.
- R9: A high `err_clr` makes `err_flag` low at the next clock edge. The clear wins over a failing compare in the same cycle.
- R10: `err_flag` is registered. A failing compare sampled at one rising edge shows on the output right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_en | input | 1 | Half-rate slot enable |
| addr_eq | input | 1 | Delay-line address compare equal |
| wr_cycle | input | 1 | Delay-line write cycle strobe |
| wr_bits | input | 2 | Data bits being written into the delay line |
| rd_bits | input | 2 | Same bits after passing through the delay line |
| cmp_valid | input | 1 | Marks the delayed copy of the captured word |
| err_clr | input | 1 | Synchronous clear of the error flag |
| err_flag | output | 1 | Sticky delay-line error flag |

## Verification
The bench counts advances up to the sampling step while it interleaves slots that carry only `half_en` or only `addr_eq`. A counter that stepped on either signal alone would sample a different word. The following compare would then disagree with the expected flag.

It drives a sampling step with `wr_cycle` low and checks that the older captured word is still the reference. A design that captured anyway, or that skipped the reload, would mis-flag. The bench also tries compares before any capture, with `cmp_valid` low, and with a clear in the same cycle as a failure. These expose a flag that trusts an empty latch, ignores the valid strobe, or gives the set priority over the clear.

Good and bad read-back patterns on each bit separately catch a compare polarity that is inverted or a bit that is swapped.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

   // How the capture latch stores the sampled write bits.
   typedef enum logic {
      POL_TRUE     = 1'b0,
      POL_INVERTED = 1'b1
   } latch_pol_e;

   localparam int unsigned DLC_DEF_CNT_W  = 4;
   localparam int unsigned DLC_DEF_RELOAD = 6;
   localparam int unsigned DLC_DEF_NBITS  = 2;

endpackage

// File: rtl/dlc_word_counter.sv
module dlc_word_counter #(
   parameter int unsigned CNT_W  = dlc_pkg::DLC_DEF_CNT_W,
   parameter int unsigned RELOAD = dlc_pkg::DLC_DEF_RELOAD
) (
   input  logic clk,
   input  logic rst_n,
   input  logic half_en,
   input  logic addr_eq,
   output logic samp_step
);

   localparam logic [CNT_W-1:0] TOP_V    = '1;
   localparam logic [CNT_W-1:0] RELOAD_V = CNT_W'(RELOAD);

   if (CNT_W < 2) begin : g_bad_width
      $error("dlc_word_counter: CNT_W must be at least 2");
   end
   if (RELOAD >= (2**CNT_W) - 1) begin : g_bad_reload
      $error("dlc_word_counter: RELOAD must be below the full count");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             step;

   assign step      = half_en & addr_eq;
   assign samp_step = step & (cnt_q == TOP_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= RELOAD_V;
      end else if (step) begin
         if (cnt_q == TOP_V) cnt_q <= RELOAD_V;
         else                cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q >= RELOAD_V); // R2
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(half_en && addr_eq) |=> $stable(cnt_q)); // R1
   AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (half_en && addr_eq && cnt_q == TOP_V) |=> cnt_q == RELOAD_V); // R3

endmodule

// File: rtl/dlc_capture_latch.sv
module dlc_capture_latch
   import dlc_pkg::*;
#(
   parameter int unsigned NBITS = DLC_DEF_NBITS,
   parameter latch_pol_e  POL   = POL_INVERTED
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic [NBITS-1:0] wr_bits,
   output logic [NBITS-1:0] lat_q,
   output logic             armed_q
);

   if (NBITS < 1) begin : g_bad_nbits
      $error("dlc_capture_latch: NBITS must be at least 1");
   end

   logic [NBITS-1:0] lat_d;

   for (genvar i = 0; i < NBITS; i++) begin : g_bit
      if (POL == POL_INVERTED) begin : g_inv
         assign lat_d[i] = ~wr_bits[i];
      end else begin : g_true
         assign lat_d[i] = wr_bits[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q   <= '0;
         armed_q <= 1'b0;
      end else if (cap) begin
         lat_q   <= lat_d;
         armed_q <= 1'b1;
      end
   end

   AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable(lat_q)); // R5
   AST_LAT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> ((POL == POL_INVERTED) ? (lat_q == ~$past(wr_bits))
                                     : (lat_q == $past(wr_bits)))); // R5

endmodule

// File: rtl/dlc_loop_compare.sv
module dlc_loop_compare
   import dlc_pkg::*;
#(
   parameter int unsigned NBITS = DLC_DEF_NBITS,
   parameter latch_pol_e  POL   = POL_INVERTED
) (
   input  logic [NBITS-1:0] lat_q,
   input  logic [NBITS-1:0] rd_bits,
   output logic [NBITS-1:0] bad_bits
);

   for (genvar i = 0; i < NBITS; i++) begin : g_bit
      logic xr;
      assign xr = lat_q[i] ^ rd_bits[i];
      if (POL == POL_INVERTED) begin : g_rev
         // Healthy: stored complement differs from returned bit.
         assign bad_bits[i] = ~xr;
      end else begin : g_dir
         assign bad_bits[i] = xr;
      end
   end

endmodule

// File: rtl/dlc_selftest.sv
module dlc_selftest
   import dlc_pkg::*;
#(
   parameter int unsigned CNT_W  = DLC_DEF_CNT_W,
   parameter int unsigned RELOAD = DLC_DEF_RELOAD,
   parameter latch_pol_e  POL    = POL_INVERTED
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       half_en,
   input  logic       addr_eq,
   input  logic       wr_cycle,
   input  logic [1:0] wr_bits,
   input  logic [1:0] rd_bits,
   input  logic       cmp_valid,
   input  logic       err_clr,
   output logic       err_flag
);

   localparam int unsigned NBITS = 2;

   logic             samp_step;
   logic             cap;
   logic [NBITS-1:0] lat_q;
   logic             armed_q;
   logic [NBITS-1:0] bad_bits;
   logic             fail;
   logic             err_q;

   dlc_word_counter #(.CNT_W(CNT_W), .RELOAD(RELOAD)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .half_en  (half_en),
      .addr_eq  (addr_eq),
      .samp_step(samp_step)
   );

   assign cap = samp_step & wr_cycle;

   dlc_capture_latch #(.NBITS(NBITS), .POL(POL)) u_lat (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap    (cap),
      .wr_bits(wr_bits),
      .lat_q  (lat_q),
      .armed_q(armed_q)
   );

   dlc_loop_compare #(.NBITS(NBITS), .POL(POL)) u_cmp (
      .lat_q   (lat_q),
      .rd_bits (rd_bits),
      .bad_bits(bad_bits)
   );

   assign fail = cmp_valid & armed_q & (|bad_bits);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err_q <= 1'b0;
      else if (err_clr) err_q <= 1'b0;
      else if (fail)    err_q <= 1'b1;
   end

   assign err_flag = err_q;

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !err_clr) |=> err_flag); // R8
   AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      err_clr |=> !err_flag); // R9
   AST_NO_SET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_flag && !cmp_valid) |=> !err_flag); // R7
   AST_NO_SET_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_flag && !armed_q) |=> !err_flag); // R7
   AST_SET_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && armed_q && !err_clr && bad_bits != '0) |=> err_flag); // R10

endmodule

// File: tb/test_dlc_selftest.sv
module test_dlc_selftest;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       half_en = 1'b0, addr_eq = 1'b0, wr_cycle = 1'b0;
   logic [1:0] wr_bits = 2'b00, rd_bits = 2'b00;
   logic       cmp_valid = 1'b0, err_clr = 1'b0;
   logic       err_flag;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // Bench reference state, derived from the requirements.
   int         m_cnt = 6;
   bit         m_armed = 1'b0;
   logic [1:0] m_cap = 2'b00;
   bit         m_flag = 1'b0;

   bit    exp_q[$];
   string tag_q[$];

   always #5 clk = ~clk;

   dlc_selftest i_dlc_selftest (
      .clk(clk), .rst_n(rst_n), .half_en(half_en), .addr_eq(addr_eq),
      .wr_cycle(wr_cycle), .wr_bits(wr_bits), .rd_bits(rd_bits),
      .cmp_valid(cmp_valid), .err_clr(err_clr), .err_flag(err_flag)
   );

   // Monitor: pops the expected flag pushed by the driver.
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         bit    e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (err_flag !== e) begin
            failures++;
            $display("FAIL %s: err_flag actual=%b expected=%b", t, err_flag, e);
         end
      end
   end

   task automatic step(input bit h, input bit a, input bit w, input logic [1:0] wb,
                       input logic [1:0] rb, input bit cv, input bit cl, input string tag);
      @(negedge clk);
      half_en = h; addr_eq = a; wr_cycle = w; wr_bits = wb;
      rd_bits = rb; cmp_valid = cv; err_clr = cl;
      @(posedge clk);
      // Compare uses the word captured before this edge.
      if (cl) m_flag = 1'b0;
      else if (cv && m_armed && (rb != m_cap)) m_flag = 1'b1;
      if (h && a) begin
         if (m_cnt == 15) begin
            m_cnt = 6;
            if (w) begin m_cap = wb; m_armed = 1'b1; end
         end else m_cnt++;
      end
      exp_q.push_back(m_flag);
      tag_q.push_back(tag);
   endtask

   task automatic advance(input int n, input bit w, input logic [1:0] wb, input string tag);
      for (int k = 0; k < n; k++) step(1, 1, w, wb, 2'b00, 0, 0, tag);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(0, 0, 0, 2'b00, 2'b00, 0, 0, "R8 idle");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (err_flag !== 1'b0) begin
         failures++;
         $display("FAIL R2: reset err_flag actual=%b expected=0", err_flag);
      end
      rst_n = 1'b1;

      // R7: compares before any capture never flag.
      step(0, 0, 0, 2'b00, 2'b11, 1, 0, "R7 unarmed");
      step(0, 0, 0, 2'b00, 2'b01, 1, 0, "R7 unarmed");

      // R3: nine advances then the sampling step captures 10.
      advance(9, 1, 2'b01, "R3 count");
      step(1, 1, 1, 2'b10, 2'b00, 0, 0, "R3 sample");
      step(0, 0, 0, 2'b00, 2'b10, 1, 0, "R5 good readback");
      step(0, 0, 0, 2'b00, 2'b11, 1, 0, "R6 bit0 bad R10");
      idle(3);
      step(0, 0, 0, 2'b00, 2'b10, 0, 1, "R9 clear");
      step(0, 0, 0, 2'b00, 2'b00, 1, 1, "R9 clear wins");
      step(0, 0, 0, 2'b00, 2'b00, 1, 0, "R6 bit1 bad");
      step(0, 0, 0, 2'b00, 2'b00, 0, 1, "R9 clear");

      // R1: partial enables must not advance the counter.
      advance(9, 1, 2'b00, "R1 count");
      for (int k = 0; k < 4; k++) begin
         step(1, 0, 1, 2'b01, 2'b10, 0, 0, "R1 half only");
         step(0, 1, 1, 2'b01, 2'b10, 0, 0, "R1 addr only");
      end
      step(0, 0, 0, 2'b00, 2'b10, 1, 0, "R1 old word kept");
      step(1, 1, 1, 2'b01, 2'b00, 0, 0, "R1 sample");
      step(0, 0, 0, 2'b00, 2'b01, 1, 0, "R5 good readback");
      step(0, 0, 0, 2'b00, 2'b10, 1, 0, "R6 both bad");
      step(0, 0, 0, 2'b00, 2'b00, 0, 1, "R9 clear");

      // R4: sampling step without write cycle keeps the old word.
      advance(9, 1, 2'b11, "R4 count");
      step(1, 1, 0, 2'b00, 2'b00, 0, 0, "R4 no write");
      step(0, 0, 0, 2'b00, 2'b01, 1, 0, "R4 old word kept");
      step(0, 0, 0, 2'b00, 2'b00, 1, 0, "R4 new word ignored");
      step(0, 0, 0, 2'b00, 2'b00, 0, 1, "R9 clear");
      // Reload check: ten more advances sample 11.
      advance(9, 1, 2'b00, "R3 reload count");
      step(1, 1, 1, 2'b11, 2'b00, 0, 0, "R3 reload sample");
      step(0, 0, 0, 2'b00, 2'b11, 1, 0, "R3 good readback");

      // R7: bad data without the valid strobe is ignored.
      step(0, 0, 0, 2'b00, 2'b00, 0, 0, "R7 no valid");
      step(1, 1, 0, 2'b00, 2'b01, 0, 0, "R7 no valid");
      step(0, 0, 0, 2'b00, 2'b01, 1, 0, "R6 late fail");

      repeat (3) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule